// File: doc/BRIEF.md
# MMU Fault Status Capture

This block sits beside a memory management unit and records why an access was aborted. For one access it takes up to five abort causes at the same time: misalignment, missing translation, domain denial, permission denial and an external bus abort. Each cause may be flagged independently. The block keeps only the most urgent cause and turns it into a 4-bit fault status code. A single qualifier on the access says whether the translation came from a section or a page, and the code depends on it. The fault address path and the status path are kept apart for data accesses and instruction fetches.

On a data abort the block writes the code and the access's domain number into a data fault status register. It also writes the modified virtual address into a fault address register. On an instruction fetch abort it writes only a separate fetch status register, and the fault address register keeps its contents. Causes that lose the priority contest are dropped and never queued. Software can rerun the access to reach them. A plain combinational read port returns any of the three registers.

All pins are plain control and status signals. The read port has no handshake: the data for `rd_sel` is valid in the same cycle and cannot be stalled.

Top module: `mmu_fault_capture`

## Requirements
- R1: When several qualified causes are flagged together, only the most urgent one is recorded. The order from most to least urgent is alignment, translation, domain, permission, external abort.
- R2: Status codes, where P is 1 for a page and 0 for a section:
  - alignment: 0001 (0011 when parameter ALIGN_ALT=1)
  - translation: 01P1
  - domain: 10P1
  - permission: 11P1
- R3: An external abort is recorded with code 10P0. On a data access it counts only when the access is non-cacheable and is either non-bufferable or a read. On a fetch it counts whenever the access is non-cacheable.
- R4: The domain field captures `dom_in` for domain, permission and external faults. It is written as 0000 for alignment and translation faults.
- R5: A data abort (`abort_is_data`=1) writes the data status register and writes `mva_in` into the fault address register. The fetch status register is left unchanged.
- R6: A fetch abort (`abort_is_data`=0) writes only the fetch status register. The data status register and the fault address register are left unchanged.
- R7: A fetch abort ignores the alignment flag. The next qualified cause is recorded instead, and if none remains nothing is written.
- R8: Registers change only on a rising clock edge where `abort_req` is 1 and at least one qualified cause is present.
- R9: After reset all three registers read as zero.
- R10: The read port selects a register with `rd_sel`:
  - 0 returns the data status register and 1 returns the fetch status register. Each is laid out as {24 zero bits, domain[3:0] in bits 7:4, code[3:0] in bits 3:0}.
  - 2 returns the fault address register.
  - 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| abort_req | input | 1 | Abort strobe for the current access |
| abort_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| flt_align | input | 1 | Misalignment cause |
| flt_xlate | input | 1 | Translation cause |
| flt_domain | input | 1 | Domain cause |
| flt_perm | input | 1 | Permission cause |
| flt_ext | input | 1 | External bus abort cause |
| acc_page | input | 1 | 1 = page mapping, 0 = section mapping |
| acc_cacheable | input | 1 | Access is cacheable |
| acc_bufferable | input | 1 | Access is bufferable |
| acc_read | input | 1 | Access is a read |
| dom_in | input | 4 | Domain number of the access |
| mva_in | input | 32 | Modified virtual address of the access |
| rd_sel | input | 2 | Register select for the read port |
| rd_data | output | 32 | Selected register contents |

## Verification
A capture appears on the read port one register stage after the edge on which `abort_req` was sampled high. The bench therefore drives each access at a falling edge and lets exactly one rising edge pass. At the next falling edge it walks `rd_sel` through all four values within the low half-cycle, before any further edge. Each sweep point is preceded by a cycle with the causes present and the strobe low, which must leave every register as it was. The sweep covers every cause combination, both access kinds, both mapping sizes and every cacheable/bufferable/read mix, and a reference model inside the bench computes the expected contents of each register.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;

  localparam int N_CAUSE = 5;
  localparam int FS_W    = 4;
  localparam int DOM_W   = 4;

  // cause index doubles as priority rank: 0 is most urgent
  typedef enum logic [2:0] {
    CZ_ALIGN  = 3'd0,
    CZ_XLATE  = 3'd1,
    CZ_DOMAIN = 3'd2,
    CZ_PERM   = 3'd3,
    CZ_EXT    = 3'd4
  } cause_e;

  typedef struct packed {
    logic          hit;
    logic [FS_W-1:0] code;
    logic          dom_ok;
  } verdict_t;

  function automatic logic [FS_W-1:0] cause_code(input int idx, input logic page,
                                                 input logic align_alt);
    logic [FS_W-1:0] c;
    case (idx)
      0:       c = align_alt ? 4'b0011 : 4'b0001;
      1:       c = {2'b01, page, 1'b1};
      2:       c = {2'b10, page, 1'b1};
      3:       c = {2'b11, page, 1'b1};
      default: c = {2'b10, page, 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fault_qualify.sv
module fault_qualify
  import mmu_fault_pkg::*;
(
  input  logic               is_data,
  input  logic               cacheable,
  input  logic               bufferable,
  input  logic               is_read,
  input  logic [N_CAUSE-1:0] raw,
  output logic [N_CAUSE-1:0] qual
);
  // external abort eligibility differs between data and fetch paths
  logic ext_ok;

  always_comb begin
    if (is_data) ext_ok = !cacheable && (!bufferable || is_read);
    else         ext_ok = !cacheable;
  end

  always_comb begin
    qual            = raw;
    qual[CZ_ALIGN]  = raw[CZ_ALIGN] && is_data;
    qual[CZ_EXT]    = raw[CZ_EXT] && ext_ok;
  end
endmodule

// File: rtl/fault_prio_enc.sv
module fault_prio_enc
  import mmu_fault_pkg::*;
#(
  parameter bit ALIGN_ALT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] qual,
  input  logic               page,
  output verdict_t           verdict
);
  logic [N_CAUSE-1:0] win;
  logic               taken;

  always_comb begin
    taken = 1'b0;
    win   = '0;
    for (int i = 0; i < N_CAUSE; i++) begin
      win[i] = qual[i] && !taken;
      taken  = taken | qual[i];
    end
  end

  logic [FS_W-1:0] code_or [N_CAUSE+1];
  assign code_or[0] = '0;

  generate
    for (genvar g = 0; g < N_CAUSE; g++) begin : g_code
      assign code_or[g+1] = code_or[g] |
                            (win[g] ? cause_code(g, page, ALIGN_ALT) : '0);
    end
  endgenerate

  always_comb begin
    verdict.hit    = |win;
    verdict.code   = code_or[N_CAUSE];
    verdict.dom_ok = win[CZ_DOMAIN] | win[CZ_PERM] | win[CZ_EXT];
  end

  // single winner: R1
  p_single_winner_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));

  // a winner exists whenever any qualified cause is present: R1
  p_hit_iff_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|qual) |-> verdict.hit);

  // only legal code shapes: R2
  p_code_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict.hit |-> (verdict.code[0] || verdict.code == 4'b1000 ||
                     verdict.code == 4'b1010));
endmodule

// File: rtl/fault_status_regs.sv
module fault_status_regs
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              is_data,
  input  logic [FS_W-1:0]   code,
  input  logic [DOM_W-1:0]  dom,
  input  logic [ADDR_W-1:0] mva,
  output logic [FS_W+DOM_W-1:0] dsr_q,
  output logic [FS_W+DOM_W-1:0] fsr_q,
  output logic [ADDR_W-1:0]     far_q
);
  localparam int SR_W = FS_W + DOM_W;

  logic [SR_W-1:0] entry;
  assign entry = {dom, code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsr_q <= '0;
      fsr_q <= '0;
      far_q <= '0;
    end else if (wr_en) begin
      if (is_data) begin
        dsr_q <= entry;
        far_q <= mva;
      end else begin
        fsr_q <= entry;
      end
    end
  end

  // idle cycles leave everything alone: R8
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dsr_q) && $stable(fsr_q) && $stable(far_q)));

  // fetch capture keeps data side and address: R6
  p_fetch_keeps_far_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_data) |=> ($stable(far_q) && $stable(dsr_q)));

  // data capture keeps fetch side: R5
  p_data_keeps_fsr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_data) |=> $stable(fsr_q));

  // address lands in FAR on a data capture: R5
  p_far_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_data) |=> (far_q == $past(mva)));
endmodule

// File: rtl/fault_read_mux.sv
module fault_read_mux
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            sel,
  input  logic [FS_W+DOM_W-1:0] dsr,
  input  logic [FS_W+DOM_W-1:0] fsr,
  input  logic [ADDR_W-1:0]     far,
  output logic [DATA_W-1:0]     rdata
);
  localparam int SR_W = FS_W + DOM_W;

  always_comb begin
    rdata = '0;
    case (sel)
      2'd0:    rdata[SR_W-1:0]   = dsr;
      2'd1:    rdata[SR_W-1:0]   = fsr;
      2'd2:    rdata[ADDR_W-1:0] = far;
      default: rdata = '0;
    endcase
  end

  // status views carry no bits above the entry: R10
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != 2'd2) |-> (rdata[DATA_W-1:SR_W] == '0));
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter bit ALIGN_ALT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_req,
  input  logic              abort_is_data,
  input  logic              flt_align,
  input  logic              flt_xlate,
  input  logic              flt_domain,
  input  logic              flt_perm,
  input  logic              flt_ext,
  input  logic              acc_page,
  input  logic              acc_cacheable,
  input  logic              acc_bufferable,
  input  logic              acc_read,
  input  logic [DOM_W-1:0]  dom_in,
  input  logic [ADDR_W-1:0] mva_in,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SR_W = FS_W + DOM_W;
  localparam logic [FS_W-1:0] ALIGN_CODE = ALIGN_ALT ? 4'b0011 : 4'b0001;

  logic [N_CAUSE-1:0] raw, qual;
  verdict_t           verdict;
  logic               wr_en;
  logic [DOM_W-1:0]   dom_w;
  logic [SR_W-1:0]    dsr, fsr;
  logic [ADDR_W-1:0]  far;

  always_comb begin
    raw            = '0;
    raw[CZ_ALIGN]  = flt_align;
    raw[CZ_XLATE]  = flt_xlate;
    raw[CZ_DOMAIN] = flt_domain;
    raw[CZ_PERM]   = flt_perm;
    raw[CZ_EXT]    = flt_ext;
  end

  fault_qualify u_qual (
    .is_data    (abort_is_data),
    .cacheable  (acc_cacheable),
    .bufferable (acc_bufferable),
    .is_read    (acc_read),
    .raw        (raw),
    .qual       (qual)
  );

  fault_prio_enc #(.ALIGN_ALT(ALIGN_ALT)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .qual    (qual),
    .page    (acc_page),
    .verdict (verdict)
  );

  assign wr_en = abort_req && verdict.hit;
  assign dom_w = verdict.dom_ok ? dom_in : '0;

  fault_status_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .is_data (abort_is_data),
    .code    (verdict.code),
    .dom     (dom_w),
    .mva     (mva_in),
    .dsr_q   (dsr),
    .fsr_q   (fsr),
    .far_q   (far)
  );

  fault_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (rd_sel),
    .dsr   (dsr),
    .fsr   (fsr),
    .far   (far),
    .rdata (rd_data)
  );

  // fetch side never records misalignment: R7
  p_fetch_no_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !abort_is_data) |=> (fsr[FS_W-1:0] != ALIGN_CODE));

  // early-stage faults carry a zero domain: R4
  p_dom_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && abort_is_data && (flt_align || flt_xlate)) |=> (dsr[SR_W-1:FS_W] == '0));
endmodule

// File: tb/mmu_fault_capture_tb.sv
`timescale 1ns/100ps
module mmu_fault_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        abort_req = 1'b0, abort_is_data = 1'b0;
  logic        flt_align = 1'b0, flt_xlate = 1'b0, flt_domain = 1'b0, flt_perm = 1'b0, flt_ext = 1'b0;
  logic        acc_page = 1'b0, acc_cacheable = 1'b0, acc_bufferable = 1'b0, acc_read = 1'b0;
  logic [3:0]  dom_in = '0;
  logic [31:0] mva_in = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mmu_fault_capture u_dut (
    .clk(clk), .rst_n(rst_n), .abort_req(abort_req), .abort_is_data(abort_is_data),
    .flt_align(flt_align), .flt_xlate(flt_xlate), .flt_domain(flt_domain),
    .flt_perm(flt_perm), .flt_ext(flt_ext), .acc_page(acc_page),
    .acc_cacheable(acc_cacheable), .acc_bufferable(acc_bufferable), .acc_read(acc_read),
    .dom_in(dom_in), .mva_in(mva_in), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  logic [31:0] m_dsr = '0, m_fsr = '0, m_far = '0;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  // read all four views inside the current low half-cycle
  task automatic read_all(input string t_dsr, input string t_fsr, input string t_far);
    rd_sel = 2'd0; #0.4; chk(rd_data, m_dsr, t_dsr);
    rd_sel = 2'd1; #0.4; chk(rd_data, m_fsr, t_fsr);
    rd_sel = 2'd2; #0.4; chk(rd_data, m_far, t_far);
    rd_sel = 2'd3; #0.4; chk(rd_data, 32'h0, "R10 sel3 zero");
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    read_all("R9 reset dsr", "R9 reset fsr", "R9 reset far");
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 1024; k++) begin
      logic d, a, t, dm, p, e, pg, c, b, r;
      logic qa, qe, hit, dv;
      logic [3:0] fs, dom;
      logic [31:0] mva;
      string tag;
      d  = k[0]; a = k[1]; t = k[2]; dm = k[3]; p = k[4]; e = k[5];
      pg = k[6]; c = k[7]; b = k[8]; r = k[9];
      dom = 4'((k * 7 + 3) & 15);
      mva = (32'(k) * 32'h0101_0101) ^ 32'hA5C3_0F00;

      abort_is_data = d; flt_align = a; flt_xlate = t; flt_domain = dm;
      flt_perm = p; flt_ext = e; acc_page = pg; acc_cacheable = c;
      acc_bufferable = b; acc_read = r; dom_in = dom; mva_in = mva;

      // strobe low: no register may move (R8)
      abort_req = 1'b0;
      @(posedge clk); @(negedge clk);
      read_all("R8 idle dsr", "R8 idle fsr", "R8 idle far");

      // reference model
      qa = a && d;
      qe = e && (d ? (!c && (!b || r)) : !c);
      hit = 1'b1; dv = 1'b0; fs = 4'h0;
      if (qa)      fs = 4'b0001;
      else if (t)  fs = pg ? 4'b0111 : 4'b0101;
      else if (dm) begin fs = pg ? 4'b1011 : 4'b1001; dv = 1'b1; end
      else if (p)  begin fs = pg ? 4'b1111 : 4'b1101; dv = 1'b1; end
      else if (qe) begin fs = pg ? 4'b1010 : 4'b1000; dv = 1'b1; end
      else hit = 1'b0;

      if (!hit)                                  tag = "R8 no cause";
      else if ((32'(qa) + 32'(t) + 32'(dm) + 32'(p) + 32'(qe)) > 1) tag = "R1 priority";
      else if (!d && a)                          tag = "R7 fetch align";
      else if (qe)                               tag = "R3 ext";
      else if (!dv)                              tag = "R4 blank dom";
      else                                       tag = "R2 code";

      if (hit) begin
        if (d) begin
          m_dsr = {24'h0, dv ? dom : 4'h0, fs};
          m_far = mva;
        end else begin
          m_fsr = {24'h0, dv ? dom : 4'h0, fs};
        end
      end

      abort_req = 1'b1;
      @(posedge clk); @(negedge clk);
      abort_req = 1'b0;
      if (d) read_all({tag, " R5 dsr"}, "R5 fsr kept", "R5 far");
      else   read_all("R6 dsr kept", {tag, " R6 fsr"}, "R6 far kept");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule